// File: doc/BRIEF.md
# Serial Flash Read Command Sequencer

This block sits on the host side of a serial flash link and runs one read transaction for each start pulse. It samples the request when the pulse arrives. It then drives a one-lane instruction byte, a 24-bit address and, for quad reads, an optional byte of mode bits. It waits through a number of turnaround cycles and shifts in the requested number of data bytes. Each captured byte comes out with a one-cycle valid strobe. Chip select stays low from the first driven bit through the last data bit. A one-cycle done pulse ends the transaction. Each step of the sequencer is one serial clock period, and `sck_en` tells the clock gating outside the block when those periods are live.

The wait between address and data comes from a four-entry table of latency values, which the host can rewrite. A 2-bit code picks the entry. The entry gives the total of mode cycles plus dummy cycles, so the sequencer uses whatever remains after the mode bits as pure dummy time.

When a quad read sends mode bits whose upper nibble is 0xA, the sequencer records that the flash now expects a repeat of the same read. The next start then skips the instruction and begins directly with the address. Any other mode value, a read without mode bits, or an abort clears that state.

Top module: `flash_rd_seq`

## Requirements
- R1: After reset, and whenever no transaction is active, `cs_n` is 1, `io_oe` is 0, `busy`, `done`, `rx_valid` and `cont_mode` are 0, and all four latency entries return to their defaults (code 0: 8, code 1: 4, code 2: 6, code 3: 10).
- R2: When the continuous flag is clear, the cycle after an accepted start begins an 8-cycle instruction phase. The opcode goes out MSB first on `io_out[0]` with `io_oe` = 4'b0001. Chip select goes low only in response to a start.
- R3: The 24-bit address follows, MSB first. A single-lane read uses 24 cycles on `io_out[0]` (`io_oe` = 4'b0001). A quad read uses 6 cycles on `io_out[3:0]` (`io_oe` = 4'b1111), with bit 3 of each nibble the more significant.
- R4: Mode bits are sent only when quad and `use_mode` are both set: 2 cycles with `io_oe` = 4'b1111, high nibble first. A single-lane read never sends mode bits, whatever `use_mode` is.
- R5: The entry selected by `lat_code` at start is the total of mode plus dummy cycles. The dummy count is that entry minus the mode cycles, and never below zero. During dummy cycles `io_oe` is 0 and `io_in` has no effect on captured data.
- R6: A write with `lat_wr_en` stores `lat_wr_val` in entry `lat_wr_idx`, and later reads that select the code use the new value.
- R7: Read data is captured MSB first. A single-lane read takes 8 cycles per byte from `io_in[1]`. A quad read takes 2 cycles per byte from `io_in[3:0]`, high nibble first. Each byte appears on `rx_data` with a one-cycle `rx_valid` pulse.
- R8: The sequencer captures exactly `rd_len` bytes, and a value of 0 counts as one byte. Chip select stays low for one unbroken stretch covering all of the transaction's phases. After the last byte, `cs_n` rises, `done` pulses for one cycle and the block is idle on the next cycle.
- R9: The continuous flag sets when mode bits with upper nibble 4'hA are sent. It clears when a transaction sends other mode bits or none. It changes at no other time.
- R10: While the continuous flag is set, a start skips the instruction phase entirely. The address phase begins the cycle after start, and `rd_opcode` is ignored.
- R11: `abort` returns the block to idle on the next cycle, with `cs_n` high and the continuous flag cleared.
- R12: A start pulse while a transaction is active is ignored. The running transaction keeps its address and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one serial step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read when idle |
| abort | input | 1 | Cancel the current read |
| rd_opcode | input | 8 | Read instruction byte |
| rd_addr | input | ADDR_W | Read start address |
| rd_mode | input | 8 | Mode byte for quad reads |
| use_mode | input | 1 | Request a mode phase |
| quad | input | 1 | 1 = four lanes for address, mode and data |
| rd_len | input | LEN_W | Number of bytes to read |
| lat_code | input | 2 | Latency table selector |
| lat_wr_en | input | 1 | Latency table write strobe |
| lat_wr_idx | input | 2 | Latency entry to write |
| lat_wr_val | input | LAT_W | New latency value |
| io_in | input | 4 | Data lanes from the flash |
| cs_n | output | 1 | Chip select, active low |
| sck_en | output | 1 | Serial clock enable for this step |
| io_out | output | 4 | Data lanes to the flash |
| io_oe | output | 4 | Per-lane output enable |
| rx_data | output | 8 | Captured read byte |
| rx_valid | output | 1 | `rx_data` valid pulse |
| done | output | 1 | Transaction finished pulse |
| busy | output | 1 | Transaction in progress |
| cont_mode | output | 1 | Continuous-read flag |

## Verification
The bench uses the default parameters: a 24-bit address, an 8-bit byte count and 4-bit latency entries. The 4-bit entries let the bench program a latency of 1, which is below the two mode cycles, so a read with no dummy time at all is reachable. With the defaults it also reaches the widest shipped latency of 10 cycles. The 8-bit count lets the bench use a zero length. The bench models the flash side at the pins. It rebuilds the opcode, address and mode bits from the lanes and counts the cycles chip select is low. It drives noise during dummy cycles and returns a known byte pattern. A sequence of reads takes the continuous flag through being set, held, broken and re-armed.

// File: rtl/frs_pkg.sv
package frs_pkg;

    localparam int OPC_W    = 8;
    localparam int MODE_W   = 8;
    localparam int BYTE_W   = 8;
    localparam int LANES    = 4;
    localparam int NCODES   = 4;
    localparam logic [3:0] CONT_KEY = 4'hA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DUMMY,
        ST_DATA,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [MODE_W-1:0] mode;
        logic              has_mode;
        logic              quad;
    } rd_ctl_t;

    function automatic int step_count(int bits, logic quad);
        return quad ? bits / LANES : bits;
    endfunction

    function automatic int lat_reset_value(int code);
        case (code)
            0:       return 8;
            1:       return 4;
            2:       return 6;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/frs_lat_table.sv
module frs_lat_table
    import frs_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_idx,
    input  logic [LAT_W-1:0] wr_val,
    input  logic [1:0]       rd_idx,
    output logic [LAT_W-1:0] rd_val
);

    logic [LAT_W-1:0] entry_q [NCODES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCODES; i++) begin
                entry_q[i] <= LAT_W'(lat_reset_value(i));
            end
        end else if (wr_en) begin
            entry_q[wr_idx] <= wr_val;
        end
    end

    assign rd_val = entry_q[rd_idx];

endmodule

// File: rtl/frs_tx_drive.sv
module frs_tx_drive
    import frs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 5
) (
    input  seq_state_e        state,
    input  rd_ctl_t           ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe
);

    int idx;

    always_comb begin
        idx    = int'(cnt);
        io_out = '0;
        io_oe  = '0;
        case (state)
            ST_CMD: begin
                io_oe     = LANES'(1);
                io_out[0] = ctl.opcode[cnt[2:0]];
            end
            ST_ADDR: begin
                if (ctl.quad) begin
                    io_oe  = '1;
                    io_out = addr[idx*LANES +: LANES];
                end else begin
                    io_oe     = LANES'(1);
                    io_out[0] = addr[idx];
                end
            end
            ST_MODE: begin
                io_oe  = '1;
                io_out = ctl.mode[idx*LANES +: LANES];
            end
            default: begin
                io_out = '0;
                io_oe  = '0;
            end
        endcase
    end

endmodule

// File: rtl/frs_rx_capture.sv
module frs_rx_capture
    import frs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic              last,
    input  logic              quad,
    input  logic [LANES-1:0]  io_in,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);

    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] sh_nx;

    always_comb begin
        if (quad) sh_nx = {sh_q[BYTE_W-LANES-1:0], io_in};
        else      sh_nx = {sh_q[BYTE_W-2:0], io_in[1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample) begin
                sh_q <= sh_nx;
                if (last) begin
                    rx_data  <= sh_nx;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
    import frs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 8,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [7:0]        rd_opcode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_mode,
    input  logic              use_mode,
    input  logic              quad,
    input  logic [LEN_W-1:0]  rd_len,
    input  logic [1:0]        lat_code,
    input  logic              lat_wr_en,
    input  logic [1:0]        lat_wr_idx,
    input  logic [LAT_W-1:0]  lat_wr_val,
    input  logic [3:0]        io_in,
    output logic              cs_n,
    output logic              sck_en,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    output logic              done,
    output logic              busy,
    output logic              cont_mode
);

    localparam int MAX_A  = (ADDR_W > OPC_W) ? ADDR_W : OPC_W;
    localparam int MAX_S  = (MAX_A > (1 << LAT_W)) ? MAX_A : (1 << LAT_W);
    localparam int CNT_W  = $clog2(MAX_S + 1);
    localparam int MODE_S = MODE_W / LANES;

    function automatic logic [CNT_W-1:0] last_step(int n);
        return CNT_W'(n - 1);
    endfunction

    seq_state_e        state_q;
    rd_ctl_t           ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LAT_W-1:0]  dummy_q;
    logic [LEN_W-1:0]  left_q;
    logic              cont_q;

    logic [LAT_W-1:0]  lat_val;
    logic              has_m_in;
    int                mode_in;
    logic [LAT_W-1:0]  dummy_in;
    seq_state_e        post_st;
    logic [CNT_W-1:0]  post_cnt;
    int                byte_steps;
    logic              step_last;

    frs_lat_table #(.LAT_W(LAT_W)) u_lat (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (lat_wr_en),
        .wr_idx (lat_wr_idx),
        .wr_val (lat_wr_val),
        .rd_idx (lat_code),
        .rd_val (lat_val)
    );

    // Start-time latency split: table gives mode + dummy
    always_comb begin
        has_m_in = use_mode & quad;
        mode_in  = has_m_in ? MODE_S : 0;
        if (int'(lat_val) > mode_in) dummy_in = LAT_W'(int'(lat_val) - mode_in);
        else                         dummy_in = '0;
    end

    // Where the sequence goes once address or mode bits are out
    always_comb begin
        byte_steps = ctl_q.quad ? BYTE_W / LANES : BYTE_W;
        step_last  = (cnt_q == '0);
        if (dummy_q != '0) begin
            post_st  = ST_DUMMY;
            post_cnt = CNT_W'(dummy_q) - CNT_W'(1);
        end else begin
            post_st  = ST_DATA;
            post_cnt = last_step(byte_steps);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
            dummy_q <= '0;
            left_q  <= '0;
            cont_q  <= 1'b0;
        end else if (abort) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cont_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ctl_q.opcode   <= rd_opcode;
                        ctl_q.mode     <= rd_mode;
                        ctl_q.has_mode <= has_m_in;
                        ctl_q.quad     <= quad;
                        addr_q         <= rd_addr;
                        dummy_q        <= dummy_in;
                        left_q         <= (rd_len == '0) ? LEN_W'(1) : rd_len;
                        if (cont_q) begin
                            state_q <= ST_ADDR;
                            cnt_q   <= last_step(step_count(ADDR_W, quad));
                        end else begin
                            state_q <= ST_CMD;
                            cnt_q   <= last_step(OPC_W);
                        end
                    end
                end
                ST_CMD: begin
                    if (step_last) begin
                        state_q <= ST_ADDR;
                        cnt_q   <= last_step(step_count(ADDR_W, ctl_q.quad));
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_ADDR: begin
                    if (step_last) begin
                        if (ctl_q.has_mode) begin
                            state_q <= ST_MODE;
                            cnt_q   <= last_step(MODE_S);
                        end else begin
                            cont_q  <= 1'b0;
                            state_q <= post_st;
                            cnt_q   <= post_cnt;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_MODE: begin
                    if (step_last) begin
                        cont_q  <= (ctl_q.mode[MODE_W-1 -: 4] == CONT_KEY);
                        state_q <= post_st;
                        cnt_q   <= post_cnt;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_DUMMY: begin
                    if (step_last) begin
                        state_q <= ST_DATA;
                        cnt_q   <= last_step(byte_steps);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (step_last) begin
                        if (left_q == LEN_W'(1)) begin
                            state_q <= ST_DONE;
                        end else begin
                            left_q <= left_q - 1'b1;
                            cnt_q  <= last_step(byte_steps);
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    frs_tx_drive #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tx (
        .state  (state_q),
        .ctl    (ctl_q),
        .addr   (addr_q),
        .cnt    (cnt_q),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

    frs_rx_capture u_rx (
        .clk      (clk),
        .rst      (rst),
        .sample   ((state_q == ST_DATA) && !abort),
        .last     (step_last),
        .quad     (ctl_q.quad),
        .io_in    (io_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    always_comb begin
        cs_n      = !((state_q == ST_CMD) || (state_q == ST_ADDR) || (state_q == ST_MODE) ||
                      (state_q == ST_DUMMY) || (state_q == ST_DATA));
        sck_en    = !cs_n;
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        cont_mode = cont_q;
    end

endmodule

// File: rtl/frs_chk.sv
module frs_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       abort,
    input logic       cs_n,
    input logic [3:0] io_oe,
    input logic       rx_valid,
    input logic       done,
    input logic       busy,
    input logic       cont_mode
);

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (io_oe == 4'b0000)); // R1

    AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> ((io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b1111))); // R3

    AST_SELECT_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> cs_n); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        done |-> cs_n); // R8

    AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R7

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && cs_n && !cont_mode)); // R11

    AST_CONT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !abort) |=> $stable(cont_mode)); // R9

endmodule

bind flash_rd_seq frs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .abort     (abort),
    .cs_n      (cs_n),
    .io_oe     (io_oe),
    .rx_valid  (rx_valid),
    .done      (done),
    .busy      (busy),
    .cont_mode (cont_mode)
);

// File: tb/flash_rd_seq_test.sv
module flash_rd_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [7:0]  rd_opcode = '0;
    logic [23:0] rd_addr = '0;
    logic [7:0]  rd_mode = '0;
    logic        use_mode = 1'b0;
    logic        quad = 1'b0;
    logic [7:0]  rd_len = '0;
    logic [1:0]  lat_code = '0;
    logic        lat_wr_en = 1'b0;
    logic [1:0]  lat_wr_idx = '0;
    logic [3:0]  lat_wr_val = '0;
    logic [3:0]  io_in = '0;
    logic        cs_n, sck_en, rx_valid, done, busy, cont_mode;
    logic [3:0]  io_out, io_oe;
    logic [7:0]  rx_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit model_cont = 1'b0;
    int model_lat [4] = '{8, 4, 6, 10};

    always #2 clk = ~clk;

    flash_rd_seq uut (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .rd_opcode(rd_opcode), .rd_addr(rd_addr), .rd_mode(rd_mode),
        .use_mode(use_mode), .quad(quad), .rd_len(rd_len), .lat_code(lat_code),
        .lat_wr_en(lat_wr_en), .lat_wr_idx(lat_wr_idx), .lat_wr_val(lat_wr_val),
        .io_in(io_in), .cs_n(cs_n), .sck_en(sck_en), .io_out(io_out), .io_oe(io_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .done(done), .busy(busy),
        .cont_mode(cont_mode)
    );

    // {opcode, addr, mode, use_mode, quad, len[3:0], code, restart}
    localparam logic [48:0] VEC [7] = '{
        {8'h0B, 24'h123456, 8'h00, 1'b0, 1'b0, 4'd3, 2'd0, 1'b0},
        {8'hEB, 24'hABCDEF, 8'hA5, 1'b1, 1'b1, 4'd2, 2'd1, 1'b1},
        {8'h6B, 24'h0F0F0F, 8'hA0, 1'b1, 1'b1, 4'd4, 2'd2, 1'b0},
        {8'hEB, 24'h800001, 8'hFF, 1'b1, 1'b1, 4'd1, 2'd3, 1'b0},
        {8'hEB, 24'h00FFFF, 8'hA3, 1'b1, 1'b1, 4'd2, 2'd0, 1'b0},
        {8'hEB, 24'h5A5A5A, 8'h00, 1'b0, 1'b1, 4'd1, 2'd1, 1'b0},
        {8'h3B, 24'hC0FFEE, 8'hA0, 1'b1, 1'b0, 4'd0, 2'd2, 1'b0}
    };

    function automatic logic [7:0] pat(int j);
        return 8'(8'hC3 ^ 8'(j * 29));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic [7:0] op, input logic [23:0] ad, input logic [7:0] md,
                           input logic um, input logic q, input logic [7:0] ln,
                           input logic [1:0] code, input logic rs);
        bit   skip   = model_cont;
        bit   has_m  = um && q;
        int   cmd_n  = skip ? 0 : 8;
        int   addr_n = q ? 6 : 24;
        int   mode_n = has_m ? 2 : 0;
        int   lat    = model_lat[code];
        int   dum_n  = (lat > mode_n) ? lat - mode_n : 0;
        int   bstep  = q ? 2 : 8;
        int   nbytes = (ln == 0) ? 1 : int'(ln);
        int   pre    = cmd_n + addr_n + mode_n + dum_n;
        int   total  = pre + nbytes * bstep;
        int   k = 0, nrx = 0, rx_bad = 0, oe_bad = 0;
        bit   seen_done = 1'b0;
        logic [7:0]  got_op = '0, got_md = '0;
        logic [23:0] got_ad = '0;
        rd_opcode = op; rd_addr = ad; rd_mode = md; use_mode = um; quad = q;
        rd_len = ln; lat_code = code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 2000 && !seen_done; c++) begin
            start = 1'b0;
            rd_addr = ad;
            if (!cs_n) begin
                if (k < cmd_n) begin
                    if (io_oe != 4'b0001) oe_bad++;
                    got_op = {got_op[6:0], io_out[0]};
                end else if (k < cmd_n + addr_n) begin
                    if (io_oe != (q ? 4'b1111 : 4'b0001)) oe_bad++;
                    got_ad = q ? {got_ad[19:0], io_out} : {got_ad[22:0], io_out[0]};
                end else if (k < cmd_n + addr_n + mode_n) begin
                    if (io_oe != 4'b1111) oe_bad++;
                    got_md = {got_md[3:0], io_out};
                end else if (k < pre) begin
                    if (io_oe != 4'b0000) oe_bad++;
                    io_in = 4'(k) ^ 4'hF;
                end else begin
                    int d = k - pre;
                    int bi = d / bstep;
                    int pos = d % bstep;
                    logic [7:0] b = pat(bi);
                    if (io_oe != 4'b0000) oe_bad++;
                    if (q) io_in = (pos == 0) ? b[7:4] : b[3:0];
                    else   io_in = {1'b1, 1'b1, b[7-pos], 1'b1};
                end
                if (rs && k == 3) begin
                    start = 1'b1;
                    rd_addr = ~ad;
                end
                k++;
            end else begin
                io_in = 4'h0;
            end
            if (rx_valid) begin
                if (rx_data != pat(nrx)) rx_bad++;
                nrx++;
            end
            if (done) seen_done = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        rd_addr = ad;
        if (!skip) chk(got_op == op, "R2", "opcode", got_op, op);
        chk(got_ad == ad, rs ? "R12" : "R3", "address", got_ad, ad);
        if (has_m) chk(got_md == md, "R4", "mode bits", got_md, md);
        chk(k == total, skip ? "R10" : "R5", "select cycles", k, total);
        chk(oe_bad == 0, has_m ? "R4" : "R5", "lane enable errors", oe_bad, 0);
        chk(nrx == nbytes, "R8", "byte count", nrx, nbytes);
        chk(rx_bad == 0, "R7", "data mismatches", rx_bad, 0);
        chk(seen_done, "R8", "done pulse", seen_done, 1);
        if (has_m) model_cont = (md[7:4] == 4'hA);
        else       model_cont = 1'b0;
        chk(cont_mode == model_cont, "R9", "continuous flag", cont_mode, model_cont);
        chk(!busy && cs_n, "R8", "idle after done", {busy, cs_n}, 2'b01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && io_oe == 4'b0000, "R1", "deselected", {cs_n, io_oe}, 5'b10000);
        chk(!busy && !done && !rx_valid && !cont_mode, "R1", "status low",
            {busy, done, rx_valid, cont_mode}, 0);

        for (int i = 0; i < 7; i++) begin
            logic [48:0] v = VEC[i];
            run_txn(v[48:41], v[40:17], v[16:9], v[8], v[7], {4'b0, v[6:3]}, v[2:1], v[0]);
        end

        // R6 rewrite code 3 to 1: below the 2 mode cycles, so no dummy time
        lat_wr_idx = 2'd3; lat_wr_val = 4'd1; lat_wr_en = 1'b1;
        @(negedge clk);
        lat_wr_en = 1'b0;
        model_lat[3] = 1;
        run_txn(8'hEB, 24'h13579B, 8'hA0, 1'b1, 1'b1, 8'd1, 2'd3, 1'b0);

        // R10 continuous start goes straight to address; R11 abort mid-address
        rd_addr = 24'h2468AC; quad = 1'b1; use_mode = 1'b1; rd_mode = 8'hA0;
        rd_len = 8'd1; lat_code = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!cs_n && io_oe == 4'b1111 && io_out == 4'h2, "R10", "first step is address",
            {cs_n, io_oe, io_out}, {1'b0, 4'b1111, 4'h2});
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(cs_n && !busy && !cont_mode && io_oe == 4'b0000, "R11", "abort idle",
            {cs_n, busy, cont_mode, io_oe}, 7'b1000000);
        model_cont = 1'b0;
        // R11 after abort the instruction phase returns
        run_txn(8'h03, 24'h000010, 8'h00, 1'b0, 1'b0, 8'd1, 2'd1, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule